// File: doc/BRIEF.md
# Storage Key Protection Checker

This block guards main memory with a small key per block. Memory is cut into 2 KiB blocks. Each block carries a 4-bit storage key and a fetch-protect flag. Every access arrives with an address, a direction (read or write), the 4-bit program key of the requester and a supervisor/user mode bit. The block decides whether the access may proceed and returns the verdict one clock later. Memory data and the delivery of any fault are left to the surrounding logic.

Keys are set through a write port that is honoured only when the requester is in supervisor mode. A write from user mode changes nothing and raises a one-cycle privileged-operation flag. A combinational read port returns the stored key and flag of any block. The default size is 32 blocks (64 KiB) on a 24-bit address.

Top module: `skey_prot`

## Requirements
- R1: After reset every block key is 0, every fetch-protect flag is 0, and `chk_valid_o` and `priv_err_o` are low.
- R2: A key write with `kw_super_i`=1 stores `kw_key_i` and `kw_fprot_i` into block `kw_blk_i`; the read port shows the new value from the following cycle.
- R3: A key write with `kw_super_i`=0 leaves the table unchanged and drives `priv_err_o` high for exactly the next cycle.
- R4: `chk_valid_o` is high in the cycle after `acc_valid_i` was sampled high, and low otherwise; `chk_allow_o` and `chk_addr_err_o` belong to that access.
- R5: In user mode a write is allowed only when the program key equals the block key, or the program key is 0, or the block key is 0.
- R6: In user mode a read of a block whose fetch-protect flag is 0 is always allowed.
- R7: In user mode a read of a block whose fetch-protect flag is 1 follows the same matching rule as a write.
- R8: In supervisor mode every access within the configured memory is allowed, whatever the keys.
- R9: An address at or beyond the configured memory size (32 blocks × 2048 bytes by default) is denied with `chk_addr_err_o`=1 in either mode; in-range accesses report `chk_addr_err_o`=0.
- R10: The block index of an access is the address shifted right by 11 bits (address / 2048).
- R11: An access sampled on the same edge as a key write to its block is judged against the key held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kw_valid_i | input | 1 | Key write request |
| kw_super_i | input | 1 | Mode of the key writer, 1 = supervisor |
| kw_blk_i | input | IDX_W | Block index to write |
| kw_key_i | input | 4 | New storage key |
| kw_fprot_i | input | 1 | New fetch-protect flag |
| kr_blk_i | input | IDX_W | Block index to read |
| kr_key_o | output | 4 | Stored key of block `kr_blk_i` |
| kr_fprot_o | output | 1 | Stored fetch-protect flag of block `kr_blk_i` |
| priv_err_o | output | 1 | User-mode key write was rejected (previous cycle) |
| acc_valid_i | input | 1 | Access check request |
| acc_addr_i | input | ADDR_W | Byte address of the access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_pkey_i | input | 4 | Program key of the requester |
| acc_super_i | input | 1 | Mode of the requester, 1 = supervisor |
| chk_valid_o | output | 1 | Verdict valid |
| chk_allow_o | output | 1 | Access allowed |
| chk_addr_err_o | output | 1 | Address beyond configured memory |

## Verification
On every cycle the assertions check the timing of the verdict against the request, the one-cycle privileged-operation flag after a rejected key write, that an addressing error never comes with a grant, and that supervisor accesses inside memory are always granted. The key matching rules for writes and reads, the effect of the fetch-protect flag, the address-to-block mapping and the old-key rule on a simultaneous write need the bench's reference model, which sweeps all program and block key pairs and compares the verdict and the read-back table every clock.

// File: rtl/skey_pkg.sv
package skey_pkg;
  localparam int unsigned BLK_SHIFT = 11;  // 2 KiB blocks
  localparam int unsigned KEY_W     = 4;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic             fprot;
  } skey_t;

  function automatic logic key_match(input logic [KEY_W-1:0] pk, input logic [KEY_W-1:0] bk);
    return (pk == bk) || (pk == '0) || (bk == '0);
  endfunction
endpackage

// File: rtl/skey_table.sv
module skey_table
  import skey_pkg::*;
#(
  parameter int unsigned NBLK  = 32,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wblk_i,
  input  skey_t            wdata_i,
  input  logic [IDX_W-1:0] ablk_i,
  output skey_t            adata_o,
  input  logic [IDX_W-1:0] rblk_i,
  output skey_t            rdata_o
);
  skey_t [NBLK-1:0] mem_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[g] <= '0;
      else if (we_i && (32'(wblk_i) == 32'(g)))        mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    adata_o = '0;
    rdata_o = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (32'(ablk_i) == 32'(i)) adata_o = mem_q[i];
      if (32'(rblk_i) == 32'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/skey_match.sv
module skey_match
  import skey_pkg::*;
(
  input  logic [KEY_W-1:0] pkey_i,
  input  skey_t            blk_i,
  input  logic             write_i,
  input  logic             super_i,
  input  logic             addr_err_i,
  output logic             allow_o
);
  logic checked;

  // reads escape the key test unless the block is fetch-protected
  assign checked = write_i || blk_i.fprot;

  always_comb begin
    if (addr_err_i)    allow_o = 1'b0;
    else if (super_i)  allow_o = 1'b1;
    else if (!checked) allow_o = 1'b1;
    else               allow_o = key_match(pkey_i, blk_i.key);
  end
endmodule

// File: rtl/skey_prot.sv
module skey_prot
  import skey_pkg::*;
#(
  parameter int unsigned MEM_BLOCKS = 32,
  parameter int unsigned ADDR_W     = 24,
  localparam int unsigned IDX_W     = (MEM_BLOCKS > 1) ? $clog2(MEM_BLOCKS) : 1,
  localparam int unsigned BLK_W     = ADDR_W - BLK_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kw_valid_i,
  input  logic              kw_super_i,
  input  logic [IDX_W-1:0]  kw_blk_i,
  input  logic [KEY_W-1:0]  kw_key_i,
  input  logic              kw_fprot_i,
  input  logic [IDX_W-1:0]  kr_blk_i,
  output logic [KEY_W-1:0]  kr_key_o,
  output logic              kr_fprot_o,
  output logic              priv_err_o,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic [KEY_W-1:0]  acc_pkey_i,
  input  logic              acc_super_i,
  output logic              chk_valid_o,
  output logic              chk_allow_o,
  output logic              chk_addr_err_o
);
  logic [BLK_W-1:0] blk_full;
  logic [IDX_W-1:0] acc_idx;
  logic             addr_err_c;
  logic             allow_c;
  logic             kw_ok;
  skey_t            acc_ent, rd_ent, wr_ent;

  assign blk_full   = acc_addr_i[ADDR_W-1:BLK_SHIFT];
  assign acc_idx    = blk_full[IDX_W-1:0];
  assign addr_err_c = 32'(blk_full) >= 32'(MEM_BLOCKS);
  assign kw_ok      = kw_valid_i && kw_super_i;
  assign wr_ent     = '{key: kw_key_i, fprot: kw_fprot_i};

  skey_table #(.NBLK(MEM_BLOCKS), .IDX_W(IDX_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (kw_ok),
    .wblk_i  (kw_blk_i),
    .wdata_i (wr_ent),
    .ablk_i  (acc_idx),
    .adata_o (acc_ent),
    .rblk_i  (kr_blk_i),
    .rdata_o (rd_ent)
  );

  skey_match u_match (
    .pkey_i     (acc_pkey_i),
    .blk_i      (acc_ent),
    .write_i    (acc_write_i),
    .super_i    (acc_super_i),
    .addr_err_i (addr_err_c),
    .allow_o    (allow_c)
  );

  assign kr_key_o   = rd_ent.key;
  assign kr_fprot_o = rd_ent.fprot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o    <= 1'b0;
      chk_allow_o    <= 1'b0;
      chk_addr_err_o <= 1'b0;
      priv_err_o     <= 1'b0;
    end else begin
      chk_valid_o    <= acc_valid_i;
      chk_allow_o    <= acc_valid_i && allow_c;
      chk_addr_err_o <= acc_valid_i && addr_err_c;
      priv_err_o     <= kw_valid_i && !kw_super_i;
    end
  end

  // R3
  priv_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kw_valid_i && !kw_super_i |=> priv_err_o);
  // R3
  priv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(kw_valid_i && !kw_super_i) |=> !priv_err_o);
  // R4
  res_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> chk_valid_o);
  // R4
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !chk_valid_o && !chk_allow_o);
  // R9
  addr_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_addr_err_o |-> !chk_allow_o);
  // R8
  super_allow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_super_i && !addr_err_c |=> chk_allow_o);
endmodule

// File: tb/tb_skey_prot.sv
`timescale 1ns/1ps
module tb_skey_prot;
  localparam int NB = 32;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kw_valid = 0, kw_super = 0, kw_fprot = 0;
  logic [4:0] kw_blk = '0, kr_blk = '0;
  logic [3:0] kw_key = '0, acc_pkey = '0;
  logic acc_valid = 0, acc_write = 0, acc_super = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [3:0] kr_key;
  logic kr_fprot, priv_err, chk_valid, chk_allow, chk_addr_err;

  int checks = 0, fails = 0;
  bit done = 0;
  int ref_key [NB];
  bit ref_fp [NB];

  always #2 clk = ~clk;

  skey_prot dut (
    .clk_i(clk), .rst_ni(rst_n),
    .kw_valid_i(kw_valid), .kw_super_i(kw_super), .kw_blk_i(kw_blk),
    .kw_key_i(kw_key), .kw_fprot_i(kw_fprot),
    .kr_blk_i(kr_blk), .kr_key_o(kr_key), .kr_fprot_o(kr_fprot),
    .priv_err_o(priv_err),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_write_i(acc_write),
    .acc_pkey_i(acc_pkey), .acc_super_i(acc_super),
    .chk_valid_o(chk_valid), .chk_allow_o(chk_allow), .chk_addr_err_o(chk_addr_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit ref_allow(int pk, int bk, bit fp, bit wr, bit sup);
    if (sup) return 1;
    if (!wr && !fp) return 1;
    return (pk == bk) || (pk == 0) || (bk == 0);
  endfunction

  // one clock: model computes from the inputs held across the edge
  task automatic step(string tag);
    int blk;
    bit aerr, e_allow;
    bit e_priv;
    blk  = int'(acc_addr >> 11);
    aerr = blk >= NB;
    e_allow = acc_valid && !aerr &&
              ref_allow(acc_pkey, ref_key[blk % NB], ref_fp[blk % NB], acc_write, acc_super);
    e_priv = kw_valid && !kw_super;
    @(posedge clk);
    #1;
    if (kw_valid && kw_super) begin
      ref_key[kw_blk] = kw_key;
      ref_fp[kw_blk]  = kw_fprot;
    end
    chk({tag, " valid"}, chk_valid, acc_valid);
    if (acc_valid) begin
      chk({tag, " allow"}, chk_allow, e_allow);
      chk({tag, " addr_err"}, chk_addr_err, aerr);
    end
    chk({tag, " priv_err"}, priv_err, e_priv);
    chk({tag, " rd_key"}, kr_key, ref_key[kr_blk]);
    chk({tag, " rd_fp"}, kr_fprot, ref_fp[kr_blk]);
    kw_valid = 0;
    acc_valid = 0;
  endtask

  task automatic kwrite(bit sup, int blk, int key, bit fp);
    kw_valid = 1; kw_super = sup; kw_blk = 5'(blk); kw_key = 4'(key); kw_fprot = fp;
    kr_blk = 5'(blk);
  endtask

  task automatic access(int addr, bit wr, int pk, bit sup);
    acc_valid = 1; acc_addr = AW'(addr); acc_write = wr; acc_pkey = 4'(pk); acc_super = sup;
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin ref_key[i] = 0; ref_fp[i] = 0; end
    #9 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 valid", chk_valid, 0);
    chk("R1 priv_err", priv_err, 0);
    for (int b = 0; b < NB; b++) begin
      kr_blk = 5'(b); #0.1;
      chk("R1 key", kr_key, 0);
      chk("R1 fp", kr_fprot, 0);
    end
    @(negedge clk);
    // R2 supervisor writes
    kwrite(1, 3, 5, 0);  step("R2");
    kwrite(1, 7, 9, 1);  step("R2");
    kwrite(1, 31, 15, 1); step("R2");
    // R5 user stores, R10 mapping (block 3 = 0x1800..0x1FFF)
    access(32'h1800, 1, 5, 0); step("R5 R10");
    access(32'h1FFF, 1, 6, 0); step("R5");
    access(32'h1900, 1, 0, 0); step("R5");
    access(32'h0100, 1, 7, 0); step("R5");
    access(32'h17FF, 1, 5, 0); step("R10");
    // R6 / R7 fetches
    access(32'h1800, 0, 6, 0); step("R6");
    access(32'h3800, 0, 6, 0); step("R7");
    access(32'h3800, 0, 9, 0); step("R7");
    access(32'h3800, 0, 0, 0); step("R7");
    // R8 supervisor
    access(32'h3800, 1, 6, 1); step("R8");
    access(32'hF800, 0, 2, 1); step("R8");
    // R3 user write ignored
    kwrite(0, 3, 1, 1); step("R3");
    access(32'h1800, 1, 5, 0); step("R3");
    // R9 range
    access(32'h10000, 1, 0, 1); step("R9");
    access(32'hFFFFFF, 0, 3, 0); step("R9");
    access(32'hFFFF, 1, 15, 0); step("R9");
    // R11 same-edge write
    kwrite(1, 3, 8, 0); access(32'h1800, 1, 5, 0); step("R11");
    access(32'h1800, 1, 5, 0); step("R11");
    // sweep of key pairs on fetch-protected and plain blocks
    for (int bk = 0; bk < 16; bk++) begin
      kwrite(1, 10, bk, bk[0]); step("R2");
      for (int pk = 0; pk < 16; pk++) begin
        access(32'h5000 + pk, 1, pk, 0); step("R5");
        access(32'h57F0 + pk, 0, pk, 0); step(bk[0] ? "R7" : "R6");
      end
    end
    access(32'h5000, 0, 3, 0); step("R4"); step("R4");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule